// File: doc/BRIEF.md
# Parallel-Scan Pseudorandom Self-Test Controller

This block runs a logic self-test over several internal scan chains at once. A single pseudorandom pattern generator, a 16-bit linear feedback shift register, supplies one bit to every chain on each shift cycle. A 16-bit multiple-input signature register takes in the bit that comes out of each chain in the same cycle, so all chains share one generator and one compactor. Both sit outside the logic under test, which needs only its internal scan paths and no ring of boundary cells.

After a start pulse the controller reseeds both registers. It then loads every chain with the programmed chain length, holding scan-enable high, and gives one capture cycle with scan-enable low. It repeats this for the programmed number of patterns. A final load pass moves the last captured response into the signature register. One cycle later, done rises and pass shows whether the signature equals the expected value. Because the chains load in parallel, a full test takes about (patterns + 1) x (length + 1) cycles, where one long serial chain would take several times more.

Top module: `pscan_bist`

## Requirements
- R1: After reset, scan_en, capture, done and pass are 0, and chain_si equals the generator seed 16'hACE1 at bits 0, 4, 8 and 12, which is 4'b0001.
- R2: A start pulse while the block is idle reseeds the generator to 16'hACE1 and the signature register to 16'h5A5A, and clears done and pass. The first shift cycle follows on the next clock.
- R3: Each pattern is chain_len consecutive cycles with scan_en=1 and capture=0, followed by exactly one cycle with capture=1 and scan_en=0. scan_en and capture are never high together.
- R4: chain_si[k] is generator bit 4k. The generator advances only in cycles with scan_en=1. On each advance it shifts toward the MSB and loads into bit 0 the XOR of bits 15, 13, 12 and 10 (polynomial x^16+x^14+x^13+x^11+1).
- R5: In every cycle with scan_en=1, the signature register shifts with the same feedback, and chain_so[k] is XORed into bit k. It holds in all other cycles.
- R6: After the last capture come chain_len unload cycles with scan_en=1, then one cycle with both strobes low. At the end of that cycle, done goes to 1 and pass goes to 1 exactly when the signature equals the expected signature.
- R7: A pattern count of 0 gives no capture cycle: only the chain_len unload cycles run, then the check.
- R8: chain_len, pat_count and exp_sig are sampled only at an accepted start. A start pulse, or a change on these inputs, while a test is running has no effect on that test.
- R9: done and pass keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a test when the block is idle |
| chain_len | input | 6 | Chain length in cycles, 1 to 32 |
| pat_count | input | 16 | Number of capture patterns |
| exp_sig | input | 16 | Expected final signature |
| chain_si | output | 4 | Serial data into each scan chain |
| chain_so | input | 4 | Serial data out of each scan chain |
| scan_en | output | 1 | High during shift and unload cycles |
| capture | output | 1 | One-cycle capture strobe |
| done | output | 1 | Test finished |
| pass | output | 1 | Final signature matched the expected value |

## Verification
The assertions assume that an accepted start always carries a chain length between 1 and 32. A length of 0 would make the shift counter wrap. The bench keeps every length in that range, including the two ends, 1 and 32.

The bench compares every cycle against a model that builds a queue of expected strobe cycles at each start and drives its own generator and signature arithmetic from the chain outputs. Its scan chains model logic that scrambles the captured data between chains. This makes a wrong tap, a wrong bit position or a slipped cycle change the final signature.

Mid-run disturbance is applied only through the start, length, count and expected-signature inputs. The effect on the strobes and the pass result is judged at the ports.

// File: rtl/pscan_pkg.sv
package pscan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_CAPT,
    ST_UNLOAD,
    ST_CHECK
  } st_t;
endpackage

// File: rtl/pscan_prpg.sv
module pscan_prpg #(
  parameter int                W    = 16,
  parameter logic [W-1:0]      TAPS = 16'hB400,
  parameter logic [W-1:0]      SEED = 16'hACE1,
  parameter int                NCH  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  output logic [NCH-1:0] chain_bits
);
  localparam int STRIDE = W / NCH;

  logic [W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst || load) st_q <= SEED;
    else if (step)   st_q <= {st_q[W-2:0], ^(st_q & TAPS)};
  end

  for (genvar k = 0; k < NCH; k++) begin : g_tap
    assign chain_bits[k] = st_q[k*STRIDE];
  end

  // R4: a maximal-length register seeded nonzero never reaches all zeros
  assert_prpg_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    st_q != '0);
  // R4: the generator moves only when a shift is requested
  assert_prpg_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(st_q));
endmodule

// File: rtl/pscan_misr.sv
module pscan_misr #(
  parameter int           W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'h5A5A,
  parameter int           NIN  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [NIN-1:0] din,
  output logic [W-1:0]   sig
);
  always_ff @(posedge clk) begin
    if (rst || load) sig <= SEED;
    else if (step)   sig <= {sig[W-2:0], ^(sig & TAPS)} ^ {{(W-NIN){1'b0}}, din};
  end

  // R5: signature holds outside shift cycles
  assert_misr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(sig));
endmodule

// File: rtl/pscan_ctrl.sv
module pscan_ctrl
  import pscan_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = $clog2(MAX_LEN+1),
  parameter int PAT_W   = 16,
  parameter int SIG_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] chain_len,
  input  logic [PAT_W-1:0] pat_count,
  input  logic [SIG_W-1:0] exp_sig,
  input  logic [SIG_W-1:0] sig,
  output logic             load,
  output logic             scan_en,
  output logic             capture,
  output logic             done,
  output logic             pass
);
  st_t              st;
  logic [LEN_W-1:0] cnt, len_q, last_bit;
  logic [PAT_W-1:0] pat_idx, pat_q, last_pat;
  logic [SIG_W-1:0] exp_q;

  assign last_bit = len_q - 1'b1;
  assign last_pat = pat_q - 1'b1;
  assign load     = (st == ST_IDLE) && start;
  assign scan_en  = (st == ST_SHIFT) || (st == ST_UNLOAD);
  assign capture  = (st == ST_CAPT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      len_q   <= '0;
      pat_idx <= '0;
      pat_q   <= '0;
      exp_q   <= '0;
      done    <= 1'b0;
      pass    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          len_q   <= chain_len;
          pat_q   <= pat_count;
          exp_q   <= exp_sig;
          cnt     <= '0;
          pat_idx <= '0;
          done    <= 1'b0;
          pass    <= 1'b0;
          st      <= (pat_count == '0) ? ST_UNLOAD : ST_SHIFT;
        end
        ST_SHIFT: begin
          if (cnt == last_bit) begin
            cnt <= '0;
            st  <= ST_CAPT;
          end else cnt <= cnt + 1'b1;
        end
        ST_CAPT: begin
          pat_idx <= pat_idx + 1'b1;
          st      <= (pat_idx == last_pat) ? ST_UNLOAD : ST_SHIFT;
        end
        ST_UNLOAD: begin
          if (cnt == last_bit) begin
            cnt <= '0;
            st  <= ST_CHECK;
          end else cnt <= cnt + 1'b1;
        end
        ST_CHECK: begin
          done <= 1'b1;
          pass <= (sig == exp_q);
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: strobes are exclusive
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(scan_en && capture));
  // R3: capture lasts one cycle
  assert_capture_single_R3: assert property (@(posedge clk) disable iff (rst)
    capture |=> !capture);
  // R3: accepted length lies in the supported range
  assert_len_range_R3: assert property (@(posedge clk) disable iff (rst)
    load |-> (chain_len != '0 && chain_len <= LEN_W'(MAX_LEN)));
  // R3: shift counter stays inside the chain
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    scan_en |-> (cnt < len_q));
  // R6: pass is only reported with done
  assert_pass_with_done_R6: assert property (@(posedge clk) disable iff (rst)
    pass |-> done);
  // R9: results hold while no start arrives
  assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(pass)));
  // R8: start during a run does not end it
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (scan_en && start) |=> !done);
endmodule

// File: rtl/pscan_bist.sv
module pscan_bist #(
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = $clog2(MAX_LEN+1),
  parameter int PAT_W   = 16,
  parameter int NCH     = 4,
  parameter int LFSR_W  = 16,
  parameter logic [LFSR_W-1:0] TAPS      = 16'hB400,
  parameter logic [LFSR_W-1:0] PRPG_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] MISR_SEED = 16'h5A5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  chain_len,
  input  logic [PAT_W-1:0]  pat_count,
  input  logic [LFSR_W-1:0] exp_sig,
  output logic [NCH-1:0]    chain_si,
  input  logic [NCH-1:0]    chain_so,
  output logic              scan_en,
  output logic              capture,
  output logic              done,
  output logic              pass
);
  logic              load;
  logic [LFSR_W-1:0] sig;

  pscan_ctrl #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .PAT_W(PAT_W), .SIG_W(LFSR_W)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .chain_len(chain_len),
    .pat_count(pat_count), .exp_sig(exp_sig), .sig(sig), .load(load),
    .scan_en(scan_en), .capture(capture), .done(done), .pass(pass));

  pscan_prpg #(.W(LFSR_W), .TAPS(TAPS), .SEED(PRPG_SEED), .NCH(NCH)) prpg_i (
    .clk(clk), .rst(rst), .load(load), .step(scan_en), .chain_bits(chain_si));

  pscan_misr #(.W(LFSR_W), .TAPS(TAPS), .SEED(MISR_SEED), .NIN(NCH)) misr_i (
    .clk(clk), .rst(rst), .load(load), .step(scan_en), .din(chain_so), .sig(sig));
endmodule

// File: tb/pscan_bist_tb_top.sv
`timescale 1ns/1ps
module pscan_bist_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  chain_len = 6'd4;
  logic [15:0] pat_count = 16'd1;
  logic [15:0] exp_sig = 16'h0;
  logic [3:0]  chain_si, chain_so;
  logic        scan_en, capture, done, pass;

  int total = 0;
  int bad = 0;
  int se_cnt = 0;
  int cap_cnt = 0;
  int cut_len = 4;

  logic [31:0] cut_q [4];
  logic [15:0] mprpg, mmisr, mexp;
  logic        m_done, m_pass;
  int          sched[$];

  always #10 clk = ~clk;

  pscan_bist dut_i (
    .clk(clk), .rst(rst), .start(start), .chain_len(chain_len),
    .pat_count(pat_count), .exp_sig(exp_sig), .chain_si(chain_si),
    .chain_so(chain_so), .scan_en(scan_en), .capture(capture),
    .done(done), .pass(pass));

  // circuit under test: four chains with cross-coupled capture logic
  always @(posedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (rst)          cut_q[k] <= 32'h1357_9BDF * (k + 1);
      else if (scan_en) cut_q[k] <= {cut_q[k][30:0], chain_si[k]};
      else if (capture) cut_q[k] <= {cut_q[k][30:0], cut_q[k][31]} ^ cut_q[(k+1)%4]
                                    ^ {16'h0, cut_q[(k+3)%4][15:0]} ^ 32'h0000_00A5;
    end
  end
  for (genvar k = 0; k < 4; k++) begin : g_so
    assign chain_so[k] = cut_q[k][cut_len-1];
  end

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    logic fb;
    fb = v[15] ^ v[13] ^ v[12] ^ v[10];
    return {v[14:0], fb};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // cycle-by-cycle reference model, evaluated at the falling edge
  always @(negedge clk) begin
    if (rst) begin
      mprpg = 16'hACE1; mmisr = 16'h5A5A; mexp = 16'h0;
      m_done = 1'b0; m_pass = 1'b0;
      sched.delete();
    end else begin
      logic es, ec;
      es = (sched.size() > 0) && (sched[0] == 1);
      ec = (sched.size() > 0) && (sched[0] == 2);
      chk(scan_en == es, "R3", "scan_en", 32'(scan_en), 32'(es));
      chk(capture == ec, "R3", "capture", 32'(capture), 32'(ec));
      chk(chain_si == {mprpg[12], mprpg[8], mprpg[4], mprpg[0]}, "R4", "chain_si",
          32'(chain_si), 32'({mprpg[12], mprpg[8], mprpg[4], mprpg[0]}));
      chk(done == m_done, "R6", "done", 32'(done), 32'(m_done));
      chk(pass == m_pass, "R6", "pass", 32'(pass), 32'(m_pass));
      if (scan_en) se_cnt++;
      if (capture) cap_cnt++;
      if (sched.size() > 0) begin
        int e;
        e = sched.pop_front();
        if (e == 1) begin
          mmisr = lfsr_next(mmisr) ^ {12'h0, chain_so};
          mprpg = lfsr_next(mprpg);
        end else if (e == 3) begin
          m_done = 1'b1;
          m_pass = (mmisr == mexp);
        end
      end else if (start) begin
        for (int p = 0; p < int'(pat_count); p++) begin
          for (int b = 0; b < int'(chain_len); b++) sched.push_back(1);
          sched.push_back(2);
        end
        for (int b = 0; b < int'(chain_len); b++) sched.push_back(1);
        sched.push_back(3);
        mprpg = 16'hACE1; mmisr = 16'h5A5A; mexp = exp_sig;
        m_done = 1'b0; m_pass = 1'b0;
      end
    end
  end

  task automatic do_reset();
    @(posedge clk); #3 rst = 1'b1;
    repeat (2) @(posedge clk);
    #3 rst = 1'b0;
    @(negedge clk); #1;
    chk(scan_en == 1'b0 && capture == 1'b0, "R1", "strobes after reset",
        32'({scan_en, capture}), 32'h0);
    chk(done == 1'b0 && pass == 1'b0, "R1", "done/pass after reset",
        32'({done, pass}), 32'h0);
    chk(chain_si == 4'b0001, "R1", "chain_si seed bits", 32'(chain_si), 32'h1);
  endtask

  // runs one test; disturb pulses start and changes inputs mid-run
  task automatic run_one(input int len, input int pats, input logic [15:0] expv,
                         input bit disturb, output logic [15:0] sig_o);
    @(posedge clk); #3;
    chain_len = 6'(len); pat_count = 16'(pats); exp_sig = expv; cut_len = len;
    start = 1'b1; se_cnt = 0; cap_cnt = 0;
    @(posedge clk); #3 start = 1'b0;
    @(negedge clk); #1;
    chk(done == 1'b0 && pass == 1'b0, "R2", "done/pass cleared at start",
        32'({done, pass}), 32'h0);
    chk(scan_en == 1'b1, "R2", "first shift follows start", 32'(scan_en), 32'h1);
    if (disturb) begin
      repeat (3) @(posedge clk);
      #3 start = 1'b1; chain_len = 6'(len + 3); pat_count = 16'(pats + 2); exp_sig = ~expv;
      @(posedge clk); #3 start = 1'b0;
    end
    while (!m_done) @(negedge clk);
    @(negedge clk); #1;
    sig_o = mmisr;
    chk(done == 1'b1, "R6", "done at end", 32'(done), 32'h1);
    chk(se_cnt == (pats + 1) * len, "R7", "shift cycle count", 32'(se_cnt), 32'((pats + 1) * len));
    chk(cap_cnt == pats, "R8", "capture count", 32'(cap_cnt), 32'(pats));
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] s1, s2, tmp;
    do_reset();
    // learn the signature of a fixed configuration
    run_one(8, 3, 16'h0BAD, 1'b0, s1);
    do_reset();
    run_one(8, 3, s1, 1'b0, s2);
    chk(pass == 1'b1, "R6", "pass on matching signature", 32'(pass), 32'h1);
    chk(s1 == s2, "R2", "reseed repeats signature", 32'(s2), 32'(s1));
    do_reset();
    run_one(8, 3, s1 ^ 16'h0001, 1'b0, tmp);
    chk(pass == 1'b0, "R6", "fail on mismatched signature", 32'(pass), 32'h0);
    // R9: results held with no start
    repeat (5) @(negedge clk);
    #1 chk(done == 1'b1 && pass == 1'b0, "R9", "done/pass hold", 32'({done, pass}), 32'h2);
    // back-to-back runs without reset, length limits
    run_one(32, 2, 16'h1234, 1'b0, tmp);
    run_one(1, 4, 16'h4321, 1'b0, tmp);
    // R7: zero patterns
    run_one(5, 0, 16'h0, 1'b0, tmp);
    chk(cap_cnt == 0, "R7", "no capture with zero patterns", 32'(cap_cnt), 32'h0);
    // R8: disturbance mid-run
    do_reset();
    run_one(6, 3, 16'h0, 1'b0, s1);
    do_reset();
    run_one(6, 3, s1, 1'b1, s2);
    chk(pass == 1'b1, "R8", "pass despite mid-run input changes", 32'(pass), 32'h1);
    chk(s1 == s2, "R5", "signature unchanged by disturbance", 32'(s2), 32'(s1));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule